// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one DMA channel that executes a circular list of 128-bit descriptors kept in system memory. Software first sets the ring's base address and its length in entries. It then moves a producer index (the head) forward. While the channel enable input is high and the consumer index (the tail) differs from the head, the engine reads the descriptor at the tail, carries it out, retires it and steps the tail. Each retired descriptor also adds one to a completion counter that software can read.

There are two descriptor kinds. A copy moves a block of memory whose length is counted in 64-byte units, using 8-byte words. A status descriptor stores one 64-bit value at an address and can raise an interrupt pulse. Software can use it to signal completion or as a fence. If software writes the head register with the value it already holds, the channel treats this as an overfilled ring and records an error. While any error bit is set the channel fetches nothing new. Software reaches the channel through a 32-bit register port. The channel reaches memory through a 64-bit request port with a valid/ready handshake and in-order read responses.

Top module: `dmr_channel`

## Requirements
- R1: After reset, head, tail, completion count and error register read 0, `irq` is low and no memory request is presented; with `chan_en` low the status register reads 0x2000_0000.
- R2: With `chan_en` high, no error pending, a non-zero ring size and tail != head, the engine reads the descriptor's first word at base + 16*tail and its second word at base + 16*tail + 8.
- R3: Type 1 in bits 63:60 of the second word is a copy. The source is the first word's bits 35:0, the length in 64-byte units is the first word's bits 59:46, and the destination is the second word's bits 35:0. Words are read from ascending source addresses, each written to the matching destination address. A length of 0 retires with no memory write.
- R4: Type 2 is a status write. The whole first word is written to the address in the second word's bits 35:0. When bit 59 of the second word is set, `irq` pulses high for one cycle after the write is accepted.
- R5: The interrupt pulse is suppressed while the owner's mask bit in the control register (offset 0x00) is set: bit 24 when parameter OWNER_HOST is 0, bit 25 when it is 1.
- R6: Each retired descriptor advances the tail (offset 0x08, read-only) by one, wrapping to 0 at the ring size. It also increments the completion count in status (offset 0x20) bits 16:0.
- R7: Writing the head register (offset 0x04) with its current value sets bit 0 of the error register (offset 0x2C) and leaves head unchanged. No descriptor is fetched while the error register is non-zero. Writing 1 to an error bit clears it.
- R8: A descriptor of any other type sets error bit 1, produces no memory write, and leaves the tail on that descriptor.
- R9: With `chan_en` low no descriptor is fetched. Dropping `chan_en` during a descriptor lets that descriptor finish and retire. The status register then shows bit 29 (quiesced) set and bit 28 (busy) clear.
- R10: Offset 0x14 holds the ring address bits 31:0. Offset 0x18 holds the ring size in bits 20:4 and address bits 35:32 in bits 3:0. Both read back as written, and a write to 0x18 resets head and tail to 0.
- R11: A memory request whose `mem_req_ready` is low stays presented with unchanged address and direction on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low stops new fetches |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 36 | Byte address, 8-byte aligned |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data returned (in order, one outstanding) |
| mem_rsp_data | input | 64 | Read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two things can land in the same clock cycle. One is a software register write: a head advance, or an error clear. The other is the engine's own tail update, or its setting of an error bit. In random rounds the head is advanced in two steps, and the second write arrives while the engine is still fetching or copying. In the error tests, a clear is written while a stalled descriptor is waiting. Results are judged at the ports. Once the engine is idle, the final tail, the completion count and the memory image must match what the bench computed. The error register must read exactly the bits that the scenario expects.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    localparam int ADDR_W    = 36;
    localparam int HI_ADDR_W = ADDR_W - 32;
    localparam int IDX_W     = 17;
    localparam int LEN_W     = 14;
    localparam int LEN_LSB   = 46;
    localparam int IRQ_BIT   = 59;
    localparam int WORD_SH   = 3;   // 8-byte words per 64-byte unit = 2**3

    localparam logic [3:0] KIND_COPY   = 4'd1;
    localparam logic [3:0] KIND_STATUS = 4'd2;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_HEAD  = 8'h04;
    localparam logic [7:0] OFF_TAIL  = 8'h08;
    localparam logic [7:0] OFF_RLO   = 8'h14;
    localparam logic [7:0] OFF_RHI   = 8'h18;
    localparam logic [7:0] OFF_STAT  = 8'h20;
    localparam logic [7:0] OFF_ERR   = 8'h2C;
    localparam logic [7:0] OFF_EMSK  = 8'h30;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_F0_REQ,
        ST_F0_WAIT,
        ST_F1_REQ,
        ST_F1_WAIT,
        ST_DECODE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_STS_REQ,
        ST_RETIRE
    } eng_state_e;

    typedef struct packed {
        logic [3:0] kind;
        logic       irq_req;
    } desc_ctl_t;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] idx,
                                                    input logic [IDX_W-1:0] size);
        logic [IDX_W-1:0] inc;
        inc = idx + 1'b1;
        return (inc == size) ? '0 : inc;
    endfunction

endpackage

// File: rtl/dmr_regs.sv
module dmr_regs
    import dmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chan_en,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 eng_busy,
    input  logic                 eng_retire,
    input  logic                 eng_bad_kind,
    output logic [IDX_W-1:0]     head_q,
    output logic [IDX_W-1:0]     tail_q,
    output logic [IDX_W-1:0]     ring_size_q,
    output logic [ADDR_W-1:0]    ring_base,
    output logic                 err_any,
    output logic [1:0]           irq_mask
);

    logic [31:0]          ring_lo_q;
    logic [HI_ADDR_W-1:0] ring_hi_q;
    logic [IDX_W-1:0]     cnt_q;
    logic [1:0]           err_q;
    logic [31:0]          emsk_q;
    logic [1:0]           mask_q;

    logic wr_head, wr_rhi, wr_err, head_same;
    logic [1:0] err_set, err_clr;
    logic quiesced;

    assign wr_head   = reg_wr && (reg_addr == OFF_HEAD);
    assign wr_rhi    = reg_wr && (reg_addr == OFF_RHI);
    assign wr_err    = reg_wr && (reg_addr == OFF_ERR);
    assign head_same = wr_head && (reg_wdata[IDX_W-1:0] == head_q);

    always_comb begin
        err_set = {eng_bad_kind, head_same};
        err_clr = wr_err ? reg_wdata[1:0] : 2'b00;
    end

    assign ring_base = {ring_hi_q, ring_lo_q};
    assign err_any   = |err_q;
    assign irq_mask  = mask_q;
    assign quiesced  = !chan_en && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q      <= '0;
            tail_q      <= '0;
            ring_size_q <= '0;
            ring_lo_q   <= '0;
            ring_hi_q   <= '0;
            cnt_q       <= '0;
            err_q       <= '0;
            emsk_q      <= '0;
            mask_q      <= '0;
        end else begin
            err_q <= (err_q & ~err_clr) | err_set;
            if (eng_retire) begin
                tail_q <= ring_next(tail_q, ring_size_q);
                cnt_q  <= cnt_q + 1'b1;
            end
            if (wr_head && !head_same)
                head_q <= reg_wdata[IDX_W-1:0];
            if (reg_wr && reg_addr == OFF_CTRL)
                mask_q <= reg_wdata[25:24];
            if (reg_wr && reg_addr == OFF_RLO)
                ring_lo_q <= reg_wdata;
            if (reg_wr && reg_addr == OFF_EMSK)
                emsk_q <= reg_wdata;
            if (wr_rhi) begin
                ring_size_q <= reg_wdata[4 +: IDX_W];
                ring_hi_q   <= reg_wdata[HI_ADDR_W-1:0];
                head_q      <= '0;
                tail_q      <= '0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = {6'b0, mask_q, 24'b0};
            OFF_HEAD: reg_rdata = {{(32-IDX_W){1'b0}}, head_q};
            OFF_TAIL: reg_rdata = {{(32-IDX_W){1'b0}}, tail_q};
            OFF_RLO:  reg_rdata = ring_lo_q;
            OFF_RHI:  reg_rdata = {{(28-IDX_W){1'b0}}, ring_size_q, ring_hi_q};
            OFF_STAT: reg_rdata = {1'b0, err_any, quiesced, eng_busy,
                                   {(28-IDX_W){1'b0}}, cnt_q};
            OFF_ERR:  reg_rdata = {30'b0, err_q};
            OFF_EMSK: reg_rdata = emsk_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R6: the tail moves only when a descriptor retires or the ring is reprogrammed
    assert_tail_only_on_retire_R6: assert property (@(posedge clk) disable iff (rst)
        (!eng_retire && !wr_rhi) |=> $stable(tail_q));

    // R7: rewriting the current head value flags overrun and keeps head
    assert_same_head_flags_R7: assert property (@(posedge clk) disable iff (rst)
        head_same |=> (err_q[0] && $stable(head_q)));

endmodule

// File: rtl/dmr_engine.sv
module dmr_engine
    import dmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 err_any,
    input  logic [IDX_W-1:0]     head,
    input  logic [IDX_W-1:0]     tail,
    input  logic [IDX_W-1:0]     ring_size,
    input  logic [ADDR_W-1:0]    ring_base,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [63:0]          mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [63:0]          mem_rsp_data,
    output logic                 busy,
    output logic                 retire,
    output logic                 bad_kind,
    output logic                 irq_evt
);

    localparam int CNT_W = LEN_W + WORD_SH;

    eng_state_e           st_q, st_nx;
    logic [63:0]          w0_q;
    desc_ctl_t            dsc_q;
    logic [ADDR_W-1:0]    src_q, dst_q;
    logic [CNT_W-1:0]     left_q;
    logic [ADDR_W-1:0]    desc_addr;
    logic [LEN_W-1:0]     copy_len;

    assign desc_addr = ring_base + ADDR_W'({tail, 4'b0000});
    assign copy_len  = w0_q[LEN_LSB +: LEN_W];
    assign busy      = (st_q != ST_IDLE);
    assign irq_evt   = (st_q == ST_RETIRE) && (dsc_q.kind == KIND_STATUS) && dsc_q.irq_req;
    assign mem_req_wdata = w0_q;

    always_comb begin
        st_nx         = st_q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = desc_addr;
        retire        = 1'b0;
        bad_kind      = 1'b0;
        case (st_q)
            ST_IDLE:
                if (enable && !err_any && (ring_size != '0) && (head != tail))
                    st_nx = ST_F0_REQ;
            ST_F0_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_nx = ST_F0_WAIT;
            end
            ST_F0_WAIT:
                if (mem_rsp_valid) st_nx = ST_F1_REQ;
            ST_F1_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_addr + ADDR_W'(8);
                if (mem_req_ready) st_nx = ST_F1_WAIT;
            end
            ST_F1_WAIT:
                if (mem_rsp_valid) st_nx = ST_DECODE;
            ST_DECODE:
                case (dsc_q.kind)
                    KIND_COPY:   st_nx = (copy_len == '0) ? ST_RETIRE : ST_RD_REQ;
                    KIND_STATUS: st_nx = ST_STS_REQ;
                    default: begin
                        bad_kind = 1'b1;
                        st_nx    = ST_IDLE;
                    end
                endcase
            ST_RD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = src_q;
                if (mem_req_ready) st_nx = ST_RD_WAIT;
            end
            ST_RD_WAIT:
                if (mem_rsp_valid) st_nx = ST_WR_REQ;
            ST_WR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dst_q;
                if (mem_req_ready)
                    st_nx = (left_q == CNT_W'(1)) ? ST_RETIRE : ST_RD_REQ;
            end
            ST_STS_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dst_q;
                if (mem_req_ready) st_nx = ST_RETIRE;
            end
            ST_RETIRE: begin
                retire = 1'b1;
                st_nx  = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            w0_q   <= '0;
            dsc_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
        end else begin
            st_q <= st_nx;
            case (st_q)
                ST_F0_WAIT:
                    if (mem_rsp_valid) w0_q <= mem_rsp_data;
                ST_F1_WAIT:
                    if (mem_rsp_valid) begin
                        dsc_q.kind    <= mem_rsp_data[63:60];
                        dsc_q.irq_req <= mem_rsp_data[IRQ_BIT];
                        dst_q         <= mem_rsp_data[ADDR_W-1:0];
                    end
                ST_DECODE: begin
                    src_q  <= w0_q[ADDR_W-1:0];
                    left_q <= {copy_len, {WORD_SH{1'b0}}};
                end
                ST_RD_WAIT:
                    if (mem_rsp_valid) w0_q <= mem_rsp_data;
                ST_WR_REQ:
                    if (mem_req_ready) begin
                        src_q  <= src_q + ADDR_W'(8);
                        dst_q  <= dst_q + ADDR_W'(8);
                        left_q <= left_q - 1'b1;
                    end
                default: ;
            endcase
        end
    end

    // R11: a stalled request keeps its address and direction
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R9: an idle, disabled channel issues nothing next cycle
    assert_no_fetch_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !mem_req_valid);

    // R4: an interrupt event follows an accepted write
    assert_irq_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        irq_evt |-> $past(mem_req_valid && mem_req_ready && mem_req_write));

    // R8: an unknown type does not retire and issues no request next cycle
    assert_bad_kind_stops_R8: assert property (@(posedge clk) disable iff (rst)
        bad_kind |=> (!mem_req_valid && !retire));

endmodule

// File: rtl/dmr_channel.sv
module dmr_channel
    import dmr_pkg::*;
#(
    parameter bit OWNER_HOST = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chan_en,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [63:0]          mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [63:0]          mem_rsp_data,
    output logic                 irq
);

    logic [IDX_W-1:0]  head, tail, ring_size;
    logic [ADDR_W-1:0] ring_base;
    logic              err_any, busy, retire, bad_kind, irq_evt, mask_sel;
    logic [1:0]        irq_mask;

    dmr_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .chan_en      (chan_en),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .eng_busy     (busy),
        .eng_retire   (retire),
        .eng_bad_kind (bad_kind),
        .head_q       (head),
        .tail_q       (tail),
        .ring_size_q  (ring_size),
        .ring_base    (ring_base),
        .err_any      (err_any),
        .irq_mask     (irq_mask)
    );

    dmr_engine u_engine (
        .clk           (clk),
        .rst           (rst),
        .enable        (chan_en),
        .err_any       (err_any),
        .head          (head),
        .tail          (tail),
        .ring_size     (ring_size),
        .ring_base     (ring_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (busy),
        .retire        (retire),
        .bad_kind      (bad_kind),
        .irq_evt       (irq_evt)
    );

    generate
        if (OWNER_HOST) begin : g_host_mask
            assign mask_sel = irq_mask[1];
        end else begin : g_dev_mask
            assign mask_sel = irq_mask[0];
        end
    endgenerate

    assign irq = irq_evt && !mask_sel;

    // R5: a masked channel never raises the interrupt line
    assert_mask_blocks_irq_R5: assert property (@(posedge clk) disable iff (rst)
        mask_sel |-> !irq);

endmodule

// File: tb/dmr_channel_tb_top.sv
module dmr_channel_tb_top;
    import dmr_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        irq;

    dmr_channel dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .irq(irq)
    );

    localparam logic [35:0] RING = 36'h1000;
    localparam int RSZ = 8;

    logic [63:0] mem [0:2047];
    logic [35:0] rd_log [0:255];
    int rd_n = 0, wr_count = 0, irq_seen = 0, hs_viol = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    function automatic int widx(input logic [35:0] a);
        return int'(a[13:3]);
    endfunction
    function automatic logic [63:0] cp_w0(input logic [35:0] s, input int len);
        return (64'(len) << 46) | 64'(s);
    endfunction
    function automatic logic [63:0] cp_w1(input logic [35:0] d);
        return (64'd1 << 60) | 64'(d);
    endfunction
    function automatic logic [63:0] st_w1(input logic [35:0] a, input bit i);
        return (64'd2 << 60) | (64'(i) << 59) | 64'(a);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory model: random ready, 0..2 cycle read latency, one outstanding
    initial begin
        bit          rd_pend = 0;
        int          rd_dly = 0;
        logic [35:0] rd_a = '0, prev_a = '0;
        bit          hold_prev = 0;
        void'($urandom(32'd1234));
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (irq) irq_seen++;
            if (hold_prev && !(mem_req_valid && mem_req_addr == prev_a)) hs_viol++;
            if (rd_pend) begin
                if (rd_dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[widx(rd_a)];
                    rd_pend = 0;
                end else rd_dly--;
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[widx(mem_req_addr)] = mem_req_wdata;
                    wr_count++;
                end else begin
                    rd_pend = 1;
                    rd_dly  = $urandom % 3;
                    rd_a    = mem_req_addr;
                    rd_log[rd_n % 256] = mem_req_addr;
                    rd_n++;
                end
            end
            hold_prev = mem_req_valid && !mem_req_ready;
            prev_a    = mem_req_addr;
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_tail(input int exp);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(OFF_TAIL, v);
            if (v == 32'(exp)) break;
        end
    endtask

    task automatic put_desc(input int slot, input logic [63:0] a, input logic [63:0] b);
        mem[widx(RING + 36'(slot * 16))]     = a;
        mem[widx(RING + 36'(slot * 16) + 8)] = b;
    endtask

    task automatic fill_copy(input int k, input int len);
        for (int j = 0; j < len * 8; j++) begin
            mem[widx(36'h2000 + 36'(k * 256 + j * 8))] = {$urandom, $urandom} | 64'h1;
            mem[widx(36'h3000 + 36'(k * 256 + j * 8))] = '0;
        end
    endtask

    function automatic int copy_bad(input int k, input int len);
        int bad = 0;
        for (int j = 0; j < len * 8; j++)
            if (mem[widx(36'h3000 + 36'(k * 256 + j * 8))] !==
                mem[widx(36'h2000 + 36'(k * 256 + j * 8))]) bad++;
        return bad;
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int h, cnt_exp, irq_exp, n, wc0, rn0;
        int kinds [0:2];
        int lens  [0:2];
        bit irqs  [0:2];
        logic [63:0] dat [0:2];

        for (int i = 0; i < 2048; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(OFF_HEAD, v); chk("R1 head", 64'(v), 0);
        rd_reg(OFF_TAIL, v); chk("R1 tail", 64'(v), 0);
        rd_reg(OFF_STAT, v); chk("R1 status", 64'(v), 64'h2000_0000);
        rd_reg(OFF_ERR, v);  chk("R1 error", 64'(v), 0);
        chk("R1 irq/valid", {62'b0, irq, mem_req_valid}, 0);

        // R10 ring programming
        wr_reg(OFF_RLO, 32'h1000);
        wr_reg(OFF_RHI, 32'(RSZ << 4));
        rd_reg(OFF_RHI, v); chk("R10 ring high", 64'(v), 64'h80);
        rd_reg(OFF_RLO, v); chk("R10 ring low", 64'(v), 64'h1000);
        chan_en = 1'b1;

        // directed: copy + status with interrupt
        fill_copy(0, 2);
        put_desc(0, cp_w0(36'h2000, 2), cp_w1(36'h3000));
        put_desc(1, 64'hA5A5_0001_DEAD_BEEF, st_w1(36'h800, 1));
        rn0 = rd_n;
        wr_reg(OFF_HEAD, 2);
        wait_tail(2);
        chk("R2 fetch word0 addr", 64'(rd_log[rn0 % 256]), 64'h1000);
        chk("R2 fetch word1 addr", 64'(rd_log[(rn0 + 1) % 256]), 64'h1008);
        chk("R3 copy mismatches", 64'(copy_bad(0, 2)), 0);
        chk("R4 status data", mem[widx(36'h800)], 64'hA5A5_0001_DEAD_BEEF);
        chk("R4 irq pulses", 64'(irq_seen), 1);
        rd_reg(OFF_STAT, v); chk("R6 count", 64'(v[16:0]), 2);

        // R5 mask
        wr_reg(OFF_CTRL, 32'h0100_0000);
        put_desc(2, 64'h1234, st_w1(36'h808, 1));
        wr_reg(OFF_HEAD, 3);
        wait_tail(3);
        chk("R5 masked data written", mem[widx(36'h808)], 64'h1234);
        chk("R5 masked irq count", 64'(irq_seen), 1);
        wr_reg(OFF_CTRL, 0);

        // random rounds, ring wraps
        h = 3; cnt_exp = 3; irq_exp = 1;
        for (int r = 0; r < 6; r++) begin
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < n; k++) begin
                kinds[k] = int'($urandom % 2);
                if (kinds[k] == 0) begin
                    lens[k] = int'($urandom % 4);
                    fill_copy(k, lens[k]);
                    put_desc((h + k) % RSZ, cp_w0(36'h2000 + 36'(k * 256), lens[k]),
                             cp_w1(36'h3000 + 36'(k * 256)));
                end else begin
                    dat[k]  = {$urandom, $urandom};
                    irqs[k] = bit'($urandom % 2);
                    mem[widx(36'h900 + 36'(k * 8))] = '0;
                    if (irqs[k]) irq_exp++;
                    put_desc((h + k) % RSZ, dat[k], st_w1(36'h900 + 36'(k * 8), irqs[k]));
                end
            end
            if (n > 1) wr_reg(OFF_HEAD, 32'((h + 1) % RSZ));
            wr_reg(OFF_HEAD, 32'((h + n) % RSZ));
            h = (h + n) % RSZ;
            cnt_exp += n;
            wait_tail(h);
            rd_reg(OFF_TAIL, v); chk("R6 tail after round", 64'(v), 64'(h));
            rd_reg(OFF_STAT, v); chk("R6 count after round", 64'(v[16:0]), 64'(cnt_exp));
            for (int k = 0; k < n; k++) begin
                if (kinds[k] == 0) chk("R3 random copy", 64'(copy_bad(k, lens[k])), 0);
                else chk("R4 random status", mem[widx(36'h900 + 36'(k * 8))], dat[k]);
            end
            chk("R4 irq total", 64'(irq_seen), 64'(irq_exp));
        end

        // R7 overrun detection
        wr_reg(OFF_HEAD, 32'(h));
        rd_reg(OFF_ERR, v);  chk("R7 overrun bit", 64'(v), 1);
        rd_reg(OFF_HEAD, v); chk("R7 head kept", 64'(v), 64'(h));
        put_desc(h, cp_w0(36'h2000, 0), cp_w1(36'h3000));
        wr_reg(OFF_HEAD, 32'((h + 1) % RSZ));
        repeat (40) @(negedge clk);
        rd_reg(OFF_TAIL, v); chk("R7 stalled tail", 64'(v), 64'(h));
        wc0 = wr_count;
        wr_reg(OFF_ERR, 1);
        h = (h + 1) % RSZ; cnt_exp++;
        wait_tail(h);
        rd_reg(OFF_TAIL, v); chk("R7 resumes after clear", 64'(v), 64'(h));
        chk("R3 zero length no write", 64'(wr_count), 64'(wc0));
        rd_reg(OFF_ERR, v); chk("R7 error cleared", 64'(v), 0);

        // R8 unknown type
        mem[widx(36'h810)] = '0;
        put_desc(h, 64'h77, (64'd3 << 60) | 64'h810);
        wc0 = wr_count;
        wr_reg(OFF_HEAD, 32'((h + 1) % RSZ));
        repeat (40) @(negedge clk);
        rd_reg(OFF_ERR, v);  chk("R8 bad type bit", 64'(v), 2);
        rd_reg(OFF_TAIL, v); chk("R8 tail held", 64'(v), 64'(h));
        chk("R8 no write", 64'(wr_count), 64'(wc0));
        put_desc(h, 64'h77, st_w1(36'h810, 0));
        wr_reg(OFF_ERR, 2);
        h = (h + 1) % RSZ; cnt_exp++;
        wait_tail(h);
        chk("R8 recovery write", mem[widx(36'h810)], 64'h77);

        // R9 enable low
        chan_en = 1'b0;
        put_desc(h, 64'h99, st_w1(36'h818, 0));
        rn0 = rd_n;
        wr_reg(OFF_HEAD, 32'((h + 1) % RSZ));
        repeat (40) @(negedge clk);
        chk("R9 no fetch when disabled", 64'(rd_n), 64'(rn0));
        rd_reg(OFF_STAT, v); chk("R9 quiesced bit", 64'(v[29]), 1);
        chan_en = 1'b1;
        h = (h + 1) % RSZ; cnt_exp++;
        wait_tail(h);
        fill_copy(0, 3);
        fill_copy(1, 3);
        put_desc(h, cp_w0(36'h2000, 3), cp_w1(36'h3000));
        put_desc((h + 1) % RSZ, cp_w0(36'h2100, 3), cp_w1(36'h3100));
        wc0 = wr_count;
        wr_reg(OFF_HEAD, 32'((h + 2) % RSZ));
        while (wr_count == wc0) @(negedge clk);
        chan_en = 1'b0;
        repeat (600) @(negedge clk);
        rd_reg(OFF_TAIL, v); chk("R9 in-flight finished", 64'(v), 64'((h + 1) % RSZ));
        rd_reg(OFF_STAT, v); chk("R9 quiesced not busy", 64'(v[29:28]), 2);
        chk("R9 first copy complete", 64'(copy_bad(0, 3)), 0);
        chan_en = 1'b1;
        h = (h + 2) % RSZ;
        wait_tail(h);
        chk("R9 second copy after enable", 64'(copy_bad(1, 3)), 0);

        // R10 reprogram resets indices
        wr_reg(OFF_RHI, 32'(RSZ << 4));
        rd_reg(OFF_HEAD, v); chk("R10 head reset", 64'(v), 0);
        rd_reg(OFF_TAIL, v); chk("R10 tail reset", 64'(v), 0);

        // R11 handshake hold observed by memory model
        chk("R11 handshake violations", 64'(hs_viol), 0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule